// File: doc/BRIEF.md
# Glitch-Free Divided Clock Output

This block drives a divided copy of the system clock onto one output pin. A free-running binary divider starts counting at reset. A 3-bit select field picks one of its taps, so the pin toggles at the system clock divided by 2, 4, 8 and so on up to 256. An enable bit in a small control register starts and stops the output.

The enable is never applied straight away. It is sampled only at the instant the selected tap is about to fall. As a result, output always begins with a full low half period and always ends right after a full high half period. No shortened pulse can reach the pin.

Two port bits sit in front of the pin: an output latch and a direction bit. The divided clock reaches the pin only when the latch is 0 and the direction bit selects output. While the output is running, or while the enable bit is set, writes to the select field are dropped, so the frequency cannot change mid-stream.

Top module: `clkout_gen`

## Requirements
- R1: After reset the control register reads 0x00, the direction bit is 1 (input, `pin_oe` low), the output latch is 0 and `pin_out` is 0.
- R2: With select code k in control bits [2:0], a running output is high for exactly 2^k cycles and low for exactly 2^k cycles. The phase follows a divider that counts system clock cycles from reset release.
- R3: The enable is control bit 4. Control bits 3, 5, 6 and 7 always read 0, whatever value was written to them.
- R4: A request to enable takes effect only when the selected tap falls. After it takes effect, the pin stays low for a full 2^k cycles before its first rise. No low interval on the pin is shorter than 2^k cycles.
- R5: A request to disable takes effect only when the selected tap falls. The last high pulse therefore always lasts exactly 2^k cycles.
- R6: When the output latch is 1 and the direction bit is 0, `pin_out` stays at 1 and no clock appears.
- R7: When the direction bit is 1, `pin_oe` is 0 and `pin_out` is 0.
- R8: A control write while the enable bit is set, or while the output is still running, updates the enable bit but leaves the select field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: [2:0] select, [4] enable |
| ctl_rdata | output | 8 | Control register readback |
| lat_we | input | 1 | Output latch write strobe |
| lat_wdata | input | 1 | Output latch write value |
| dir_we | input | 1 | Direction bit write strobe |
| dir_wdata | input | 1 | Direction write value, 1 = input |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench builds the block with its default parameters: a 3-bit select and an 8-bit divider. This makes every ratio from 2 to 256 reachable, including the slowest one, whose half period of 128 cycles must survive enable and disable requests that land at arbitrary divider phases. Random enable toggles with random dwell times cover requests that arrive mid-high, mid-low and exactly at a falling tap. Every completed high pulse is measured against 2^k, and every low gap against the minimum of 2^k. Select writes that arrive while running, and changes to the latch and direction bits, are also covered.

// File: rtl/clkout_gen.sv
module clkout_gen #(
  parameter int SEL_W  = 3,
  parameter int CTL_W  = 8,
  parameter int EN_POS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             lat_we,
  input  logic             lat_wdata,
  input  logic             dir_we,
  input  logic             dir_wdata,
  output logic             pin_out,
  output logic             pin_oe
);
  localparam int DIV_W = 1 << SEL_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] low_mask;
  logic [SEL_W-1:0] sel_q;
  logic             en_q, run_q, lat_q, dir_q;
  logic             tap, tap_fall;

  assign tap      = div_q[sel_q];
  assign low_mask = (DIV_W'(1) << sel_q) - DIV_W'(1);
  assign tap_fall = tap && ((div_q & low_mask) == low_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      sel_q <= '0;
      en_q  <= 1'b0;
      run_q <= 1'b0;
      lat_q <= 1'b0;
      dir_q <= 1'b1;
    end else begin
      div_q <= div_q + DIV_W'(1);
      if (tap_fall) run_q <= en_q;
      if (ctl_we) begin
        en_q <= ctl_wdata[EN_POS];
        if (!en_q && !run_q) sel_q <= ctl_wdata[SEL_W-1:0];
      end
      if (lat_we) lat_q <= lat_wdata;
      if (dir_we) dir_q <= dir_wdata;
    end
  end

  always_comb begin
    ctl_rdata              = '0;
    ctl_rdata[SEL_W-1:0]   = sel_q;
    ctl_rdata[EN_POS]      = en_q;
  end

  assign pin_oe  = ~dir_q;
  assign pin_out = ~dir_q & (lat_q | (run_q & tap));
endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk #(
  parameter int SEL_W  = 3,
  parameter int CTL_W  = 8,
  parameter int EN_POS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             tap,
  input logic [SEL_W-1:0] sel_q,
  input logic             lat_q,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             pin_out,
  input logic             pin_oe
);
  localparam logic [CTL_W-1:0] LIVE = CTL_W'((1 << SEL_W) - 1) | (CTL_W'(1) << EN_POS);

  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> !tap);
  p_stop_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(tap) && !tap));
  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(sel_q));
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata & ~LIVE) == '0);
  p_latch_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && lat_q) |-> pin_out);
  p_input_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);
endmodule

bind clkout_gen clkout_gen_chk #(.SEL_W(SEL_W), .CTL_W(CTL_W), .EN_POS(EN_POS)) i_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .tap(tap), .sel_q(sel_q), .lat_q(lat_q),
  .ctl_rdata(ctl_rdata), .pin_out(pin_out), .pin_oe(pin_oe));

// File: tb/test_clkout_gen.sv
module test_clkout_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       lat_we = 1'b0, lat_wdata = 1'b0;
  logic       dir_we = 1'b0, dir_wdata = 1'b0;
  logic       pin_out, pin_oe;

  int errs = 0, checks = 0;
  bit live = 0, done = 0;

  // reference model state
  int m_tick, m_sel;
  bit m_en, m_run, m_lat, m_dir;

  // pulse width tracking
  bit seg_ok = 0, prev_lvl = 0;
  int seg_len = 0;

  always #2 clk = ~clk;

  clkout_gen i_clkout_gen (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .lat_we(lat_we), .lat_wdata(lat_wdata), .dir_we(dir_we), .dir_wdata(dir_wdata),
    .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit phase(input int t, input int s);
    return ((t >> s) & 1) == 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_sel = 0; m_en = 0; m_run = 0; m_lat = 0; m_dir = 1;
    end else begin
      bit fall, n_run;
      fall  = phase(m_tick, m_sel) && !phase(m_tick + 1, m_sel);
      n_run = fall ? m_en : m_run;
      if (ctl_we) begin
        if (!m_en && !m_run) m_sel = int'(ctl_wdata[2:0]);
        m_en = ctl_wdata[4];
      end
      m_run = n_run;
      if (lat_we) m_lat = lat_wdata;
      if (dir_we) m_dir = dir_wdata;
      m_tick++;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      bit e_pin;
      int e_rd;
      e_pin = !m_dir && (m_lat || (m_run && phase(m_tick, m_sel)));
      e_rd  = (int'(m_en) << 4) | m_sel;
      chk(pin_out == e_pin, "R2 pin level", pin_out, e_pin);
      chk(pin_oe == !m_dir, "R7 pin_oe", pin_oe, !m_dir);
      chk(int'(ctl_rdata) == e_rd, "R3 readback", ctl_rdata, e_rd);
      if (m_dir || m_lat) begin
        seg_ok = 0; seg_len = 0;
      end else if (pin_out != prev_lvl) begin
        if (seg_ok) begin
          if (prev_lvl) chk(seg_len == (1 << m_sel), "R5 high width", seg_len, 1 << m_sel);
          else chk(seg_len >= (1 << m_sel), "R4 low width", seg_len, 1 << m_sel);
        end
        seg_ok = 1; seg_len = 1;
      end else seg_len++;
      prev_lvl = pin_out;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_lat(input logic v);
    @(negedge clk); lat_we = 1; lat_wdata = v;
    @(negedge clk); lat_we = 0;
  endtask

  task automatic wr_dir(input logic v);
    @(negedge clk); dir_we = 1; dir_wdata = v;
    @(negedge clk); dir_we = 0;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    @(negedge clk);
    chk(ctl_rdata == 8'h00, "R1 ctl reset", ctl_rdata, 0);
    chk(pin_oe == 1'b0, "R1 direction reset", pin_oe, 0);
    chk(pin_out == 1'b0, "R1 pin reset", pin_out, 0);
    live = 1;

    wr_ctl(8'hEB);
    chk(ctl_rdata == 8'h03, "R3 reserved bits", ctl_rdata, 8'h03);
    tick(20);
    chk(pin_out == 1'b0, "R7 input mode quiet", pin_out, 0);
    wr_dir(0);
    wr_ctl(8'h13);
    tick(200);
    wr_ctl(8'h15);
    chk(ctl_rdata == 8'h13, "R8 select held while enabled", ctl_rdata, 8'h13);
    tick(100);
    wr_ctl(8'h05);
    chk(ctl_rdata[2:0] == 3'd3, "R8 select held while stopping", ctl_rdata[2:0], 3);
    tick(40);
    wr_ctl(8'h00);
    chk(ctl_rdata == 8'h00, "R8 select accepted when idle", ctl_rdata, 0);
    wr_ctl(8'h10);
    tick(50);

    wr_lat(1);
    tick(30);
    chk(pin_out == 1'b1, "R6 latch forces high", pin_out, 1);
    wr_lat(0);
    tick(30);
    wr_dir(1);
    tick(10);
    chk(pin_oe == 1'b0 && pin_out == 1'b0, "R7 input mode", pin_out, 0);
    wr_dir(0);
    wr_ctl(8'h00);
    tick(300);

    for (int i = 0; i < 60; i++) begin
      logic [2:0] s;
      s = 3'($urandom_range(0, 7));
      wr_ctl({5'b0, s});
      tick($urandom_range(0, 300));
      wr_ctl({4'b0001, 1'b0, s});
      tick($urandom_range(1, 600));
      if ($urandom_range(0, 3) == 0) wr_ctl({4'b0001, 1'b0, 3'(s + 3'd1)});
      wr_ctl(8'h00);
      tick($urandom_range(0, 300));
    end
    tick(600);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule